// File: doc/BRIEF.md
# Two-Wire EEPROM Slave with Page Latch and Program Cycle

This block is the device side of a two-wire serial EEPROM, seen at the level of byte events. A bus front end, outside this block, decodes the line conditions and hands over a one-cycle START pulse, a one-cycle STOP pulse, and each received byte with a valid strobe. The block decides whether to acknowledge each byte. It answers read requests with bytes from its array.

A write transfer has three parts: a device-select byte with the direction bit clear, an address byte, then data bytes. The data bytes land in an eight-byte page latch. They are indexed by the low three bits of the address counter, which wrap inside the page, so a long burst overwrites earlier bytes. The upper address bits keep the value set in the address phase. A STOP after at least one data byte starts an internal program cycle that lasts `PROG_CYCLES` clocks. During that cycle the block ignores every input and acknowledges nothing. At the end of the cycle it copies the latched bytes into the array. A host can therefore poll with START plus device-select until it sees an acknowledge.

A device-select byte with the direction bit set enters the read phase. Each read request returns the byte at the current address, and the counter then advances with the same low-bit wrap.

The controller state machine has seven states:

- `ST_IDLE` waits for a START.
- `ST_DEVSEL` expects the device-select byte.
- `ST_ADDR` expects the address byte.
- `ST_WDATA` takes write data.
- `ST_RDATA` serves reads.
- `ST_IGNORE` waits, after a device select that did not match, for the next START.
- `ST_PROG` runs the program cycle.

The transitions are:

- A START leads from any state except `ST_PROG` to `ST_DEVSEL`.
- In `ST_DEVSEL`, a matching select leads to `ST_ADDR` or `ST_RDATA`, and a select that does not match leads to `ST_IGNORE`.
- The address byte leads from `ST_ADDR` to `ST_WDATA`.
- A STOP in `ST_WDATA` with latched data leads to `ST_PROG`. Any other STOP leads to `ST_IDLE`.
- When the program timer expires, `ST_PROG` returns to `ST_IDLE`.

Top module: `eeprom_page_slave`

## Requirements
- R1: After reset, `ack_o` and `rd_valid_o` are 0 and every array byte reads as 0x00.
- R2: A device-select byte whose bits [7:1] equal `DEV_ADDR` (default 7'h50) is acknowledged. Bit 0 selects the direction: 0 for write, 1 for read. A select byte that does not match is not acknowledged, and no further byte is acknowledged until the next START.
- R3: In a write transfer, the address byte and every data byte are acknowledged. The address byte loads the counter. Each data byte goes to page slot `addr[2:0]`, and only `addr[2:0]` then increments, wrapping from 7 to 0. `addr[6:3]` is unchanged.
- R4: Writing more than eight data bytes overwrites the slots written earlier in the same transfer, and the last value written to each slot is the one committed.
- R5: A STOP after at least one data byte starts a program cycle of exactly `PROG_CYCLES` clocks. At its end, only the slots written in that transfer are copied into the array page selected by `addr[6:3]`. The other bytes of that page keep their values.
- R6: During the program cycle, no byte is acknowledged, and START, STOP and read requests have no effect. In particular, `rd_valid_o` stays 0.
- R7: The first START and device-select after the program cycle ends are handled normally, and the device-select byte is acknowledged.
- R8: A STOP with no data byte since the address phase starts no program cycle. A device select right afterwards is acknowledged.
- R9: In the read phase, each read request yields `rd_valid_o`=1 with the byte at the current address on the next cycle. The low three address bits then increment with wrap. Bytes received in the read phase are not acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle pulse: START or repeated START seen on the bus |
| stop_i | input | 1 | One-cycle pulse: STOP seen on the bus |
| byte_valid_i | input | 1 | One-cycle strobe: `rx_byte_i` holds a received byte |
| rx_byte_i | input | 8 | Received byte |
| rd_req_i | input | 1 | One-cycle request for the next read byte |
| ack_o | output | 1 | Acknowledge decision for the byte strobed one cycle earlier |
| rd_data_o | output | 8 | Read byte, valid while `rd_valid_o` is 1 |
| rd_valid_o | output | 1 | One-cycle strobe: `rd_data_o` holds a read byte |

## Verification
The acknowledge decision is registered and appears one cycle after the byte strobe. A read byte likewise appears one cycle after its request. The bench drives each event for one clock from a falling edge and samples at the next falling edge, which is exactly where these registered results are due. The program cycle occupies exactly `PROG_CYCLES` clocks after the edge that takes the STOP. The bench therefore places a START on the last busy edge and expects the following select to go unacknowledged, then places a START one edge after the cycle ends and expects an acknowledge. A cycle that is one clock too short or one clock too long fails one of these two checks.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEVSEL,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_PROG,
        ST_IGNORE
    } slave_state_t;

endpackage

// File: rtl/eeprom_ctrl_fsm.sv
module eeprom_ctrl_fsm
    import eeprom_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h50,
    parameter int         PROG_CYCLES = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic         stop_i,
    input  logic         byte_valid_i,
    input  logic [7:0]   rx_byte_i,
    input  logic         rd_req_i,
    input  logic         page_dirty_i,
    output slave_state_t state_o,
    output logic         ack_o,
    output logic         addr_load_o,
    output logic         data_wr_o,
    output logic         rd_step_o,
    output logic         commit_o
);

    localparam int TW = $clog2(PROG_CYCLES + 1);
    localparam logic [TW-1:0] TIMER_LOAD = TW'(PROG_CYCLES - 1);

    slave_state_t    state_q, state_d;
    logic [TW-1:0]   timer_q;
    logic            ack_d;
    logic            sel_hit;
    logic            prog_enter;
    logic            bus_event;

    assign sel_hit    = (rx_byte_i[7:1] == DEV_ADDR);
    assign bus_event  = start_i | stop_i;
    assign prog_enter = (state_d == ST_PROG) && (state_q != ST_PROG);
    assign state_o    = state_q;

    // State register, program timer and registered acknowledge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            timer_q <= '0;
            ack_o   <= 1'b0;
        end else begin
            state_q <= state_d;
            ack_o   <= ack_d;
            if (prog_enter) begin
                timer_q <= TIMER_LOAD;
            end else if (state_q == ST_PROG && timer_q != '0) begin
                timer_q <= timer_q - 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        if (state_q == ST_PROG) begin
            if (timer_q == '0) begin
                state_d = ST_IDLE;
            end
        end else if (start_i) begin
            state_d = ST_DEVSEL;
        end else if (stop_i) begin
            state_d = (state_q == ST_WDATA && page_dirty_i) ? ST_PROG : ST_IDLE;
        end else if (byte_valid_i) begin
            unique case (state_q)
                ST_DEVSEL: state_d = sel_hit ? (rx_byte_i[0] ? ST_RDATA : ST_ADDR)
                                             : ST_IGNORE;
                ST_ADDR:   state_d = ST_WDATA;
                default:   state_d = state_q;
            endcase
        end
    end

    // Output strobes
    always_comb begin
        ack_d       = 1'b0;
        addr_load_o = 1'b0;
        data_wr_o   = 1'b0;
        rd_step_o   = 1'b0;
        commit_o    = (state_q == ST_PROG) && (timer_q == '0);
        if (state_q != ST_PROG && !bus_event) begin
            unique case (state_q)
                ST_DEVSEL: ack_d = byte_valid_i && sel_hit;
                ST_ADDR: begin
                    ack_d       = byte_valid_i;
                    addr_load_o = byte_valid_i;
                end
                ST_WDATA: begin
                    ack_d     = byte_valid_i;
                    data_wr_o = byte_valid_i;
                end
                ST_RDATA:  rd_step_o = rd_req_i;
                default:   ack_d = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/eeprom_addr_ctr.sv
module eeprom_addr_ctr #(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam int HI_W = ADDR_W - PAGE_W;

    logic [HI_W-1:0]   hi_q;
    logic [PAGE_W-1:0] lo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else if (load_i) begin
            hi_q <= load_val_i[ADDR_W-1:PAGE_W];
            lo_q <= load_val_i[PAGE_W-1:0];
        end else if (step_i) begin
            lo_q <= lo_q + 1'b1;
        end
    end

    assign addr_o = {hi_q, lo_q};

endmodule

// File: rtl/eeprom_page_buf.sv
module eeprom_page_buf #(
    parameter int PAGE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     wr_i,
    input  logic [PAGE_W-1:0]        idx_i,
    input  logic [7:0]               data_i,
    output logic [8*(2**PAGE_W)-1:0] bytes_o,
    output logic [(2**PAGE_W)-1:0]   mask_o,
    output logic                     dirty_o
);

    localparam int PAGE_BYTES = 2 ** PAGE_W;

    for (genvar s = 0; s < PAGE_BYTES; s++) begin : g_slot
        logic [7:0] byte_q;
        logic       used_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                used_q <= 1'b0;
            end else if (clear_i) begin
                used_q <= 1'b0;
            end else if (wr_i && idx_i == PAGE_W'(s)) begin
                byte_q <= data_i;
                used_q <= 1'b1;
            end
        end

        assign bytes_o[8*s +: 8] = byte_q;
        assign mask_o[s]         = used_q;
    end

    assign dirty_o = |mask_o;

endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     commit_i,
    input  logic [ADDR_W-PAGE_W-1:0] page_i,
    input  logic [8*(2**PAGE_W)-1:0] bytes_i,
    input  logic [(2**PAGE_W)-1:0]   mask_i,
    input  logic                     rd_i,
    input  logic [ADDR_W-1:0]        rd_addr_i,
    output logic [7:0]               rd_data_o,
    output logic                     rd_valid_o
);

    localparam int DEPTH      = 2 ** ADDR_W;
    localparam int PAGE_BYTES = 2 ** PAGE_W;
    localparam int HI_W       = ADDR_W - PAGE_W;

    logic [7:0] mem_w [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        localparam int              SLOT = w % PAGE_BYTES;
        localparam logic [HI_W-1:0] PG   = HI_W'(w / PAGE_BYTES);
        logic [7:0] word_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (commit_i && page_i == PG && mask_i[SLOT]) begin
                word_q <= bytes_i[8*SLOT +: 8];
            end
        end

        assign mem_w[w] = word_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_o  <= '0;
            rd_valid_o <= 1'b0;
        end else begin
            rd_valid_o <= rd_i;
            if (rd_i) begin
                rd_data_o <= mem_w[rd_addr_i];
            end
        end
    end

endmodule

// File: rtl/eeprom_page_slave.sv
module eeprom_page_slave
    import eeprom_pkg::*;
#(
    parameter int         ADDR_W      = 7,
    parameter int         PAGE_W      = 3,
    parameter int         PROG_CYCLES = 16,
    parameter logic [6:0] DEV_ADDR    = 7'h50
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       stop_i,
    input  logic       byte_valid_i,
    input  logic [7:0] rx_byte_i,
    input  logic       rd_req_i,
    output logic       ack_o,
    output logic [7:0] rd_data_o,
    output logic       rd_valid_o
);

    localparam int PAGE_BYTES = 2 ** PAGE_W;
    localparam int HI_W       = ADDR_W - PAGE_W;

    slave_state_t              state;
    logic [ADDR_W-1:0]         addr_q;
    logic                      addr_load, data_wr, rd_step, commit;
    logic                      page_dirty;
    logic [8*PAGE_BYTES-1:0]   page_bytes;
    logic [PAGE_BYTES-1:0]     page_mask;

    eeprom_ctrl_fsm #(
        .DEV_ADDR    (DEV_ADDR),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .stop_i       (stop_i),
        .byte_valid_i (byte_valid_i),
        .rx_byte_i    (rx_byte_i),
        .rd_req_i     (rd_req_i),
        .page_dirty_i (page_dirty),
        .state_o      (state),
        .ack_o        (ack_o),
        .addr_load_o  (addr_load),
        .data_wr_o    (data_wr),
        .rd_step_o    (rd_step),
        .commit_o     (commit)
    );

    eeprom_addr_ctr #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (addr_load),
        .load_val_i (rx_byte_i[ADDR_W-1:0]),
        .step_i     (data_wr | rd_step),
        .addr_o     (addr_q)
    );

    eeprom_page_buf #(
        .PAGE_W (PAGE_W)
    ) u_page (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (addr_load | commit),
        .wr_i    (data_wr),
        .idx_i   (addr_q[PAGE_W-1:0]),
        .data_i  (rx_byte_i),
        .bytes_o (page_bytes),
        .mask_o  (page_mask),
        .dirty_o (page_dirty)
    );

    eeprom_store #(
        .ADDR_W (ADDR_W),
        .PAGE_W (PAGE_W)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .commit_i   (commit),
        .page_i     (addr_q[ADDR_W-1:PAGE_W]),
        .bytes_i    (page_bytes),
        .mask_i     (page_mask),
        .rd_i       (rd_step),
        .rd_addr_i  (addr_q),
        .rd_data_o  (rd_data_o),
        .rd_valid_o (rd_valid_o)
    );

    logic [HI_W-1:0] unused_hi;
    assign unused_hi = addr_q[ADDR_W-1:PAGE_W];

endmodule

// File: rtl/eeprom_page_slave_chk.sv
module eeprom_page_slave_chk
    import eeprom_pkg::*;
#(
    parameter int ADDR_W      = 7,
    parameter int PAGE_W      = 3,
    parameter int PROG_CYCLES = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_i,
    input logic              byte_valid_i,
    input logic              ack_o,
    input logic              rd_valid_o,
    input slave_state_t      state,
    input logic [ADDR_W-1:0] addr
);

    int unsigned prog_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prog_cnt <= 0;
        else        prog_cnt <= (state == ST_PROG) ? prog_cnt + 1 : 0;
    end

    AST_ACK_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_o |-> $past(byte_valid_i)); // R2

    AST_UPPER_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WDATA && $past(state) == ST_WDATA) |->
            $stable(addr[ADDR_W-1:PAGE_W])); // R3

    AST_PROG_FROM_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_PROG) |-> $past(stop_i)); // R5

    AST_PROG_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(state == ST_PROG) |-> prog_cnt == PROG_CYCLES); // R5

    AST_NO_ACK_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |=> !ack_o); // R6

    AST_NO_READ_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |=> !rd_valid_o); // R6

endmodule

bind eeprom_page_slave eeprom_page_slave_chk #(
    .ADDR_W      (ADDR_W),
    .PAGE_W      (PAGE_W),
    .PROG_CYCLES (PROG_CYCLES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .stop_i       (stop_i),
    .byte_valid_i (byte_valid_i),
    .ack_o        (ack_o),
    .rd_valid_o   (rd_valid_o),
    .state        (state),
    .addr         (addr_q)
);

// File: tb/eeprom_page_slave_bench.sv
`timescale 1ns/1ps
module eeprom_page_slave_bench;

    localparam int PROG_C = 16;
    localparam int OP_S = 0, OP_P = 1, OP_B = 2, OP_RD = 3, OP_I = 4;
    localparam int NV = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, stop_i = 1'b0, byte_valid_i = 1'b0, rd_req_i = 1'b0;
    logic [7:0] rx_byte_i = '0;
    logic ack_o, rd_valid_o;
    logic [7:0] rd_data_o;

    int errors = 0;
    int checks = 0;

    always #2 clk = ~clk;

    eeprom_page_slave #(
        .ADDR_W (7), .PAGE_W (3), .PROG_CYCLES (PROG_C), .DEV_ADDR (7'h50)
    ) u_eeprom_page_slave (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .stop_i (stop_i),
        .byte_valid_i (byte_valid_i), .rx_byte_i (rx_byte_i), .rd_req_i (rd_req_i),
        .ack_o (ack_o), .rd_data_o (rd_data_o), .rd_valid_o (rd_valid_o)
    );

    function automatic logic [22:0] v(input int op, input logic [7:0] d,
                                      input logic [7:0] e, input int req);
        return {3'(op), d, e, 4'(req)};
    endfunction

    // {op, data, expected (ack in bit 0 for bytes, data for reads), requirement}
    localparam logic [22:0] VEC [NV] = '{
        v(OP_S,0,0,2),      v(OP_B,8'hA0,1,2),  v(OP_B,8'h10,1,3),  v(OP_B,8'h11,1,3),
        v(OP_B,8'h22,1,3),  v(OP_B,8'h33,1,3),  v(OP_P,0,0,5),      v(OP_I,20,0,5),
        v(OP_S,0,0,7),      v(OP_B,8'hA0,1,7),  v(OP_B,8'h10,1,3),  v(OP_S,0,0,9),
        v(OP_B,8'hA1,1,9),  v(OP_RD,0,8'h11,9), v(OP_RD,0,8'h22,9), v(OP_RD,0,8'h33,9),
        v(OP_RD,0,8'h00,5), v(OP_B,8'h77,0,9),  v(OP_P,0,0,9),      v(OP_S,0,0,2),
        v(OP_B,8'hA2,0,2),  v(OP_B,8'h55,0,2),  v(OP_P,0,0,2),      v(OP_S,0,0,8),
        v(OP_B,8'hA0,1,8),  v(OP_B,8'h20,1,8),  v(OP_P,0,0,8),      v(OP_S,0,0,8),
        v(OP_B,8'hA0,1,8),  v(OP_B,8'h2E,1,4),  v(OP_B,8'h40,1,4),  v(OP_B,8'h41,1,4),
        v(OP_B,8'h42,1,4),  v(OP_B,8'h43,1,4),  v(OP_B,8'h44,1,4),  v(OP_B,8'h45,1,4),
        v(OP_B,8'h46,1,4),  v(OP_B,8'h47,1,4),  v(OP_B,8'h48,1,4),  v(OP_B,8'h49,1,4),
        v(OP_P,0,0,4),      v(OP_I,20,0,4),     v(OP_S,0,0,4),      v(OP_B,8'hA0,1,4),
        v(OP_B,8'h28,1,4),  v(OP_S,0,0,4),      v(OP_B,8'hA1,1,4),  v(OP_RD,0,8'h42,4),
        v(OP_RD,0,8'h43,4), v(OP_RD,0,8'h44,4), v(OP_RD,0,8'h45,4), v(OP_RD,0,8'h46,4),
        v(OP_RD,0,8'h47,4), v(OP_RD,0,8'h48,4), v(OP_RD,0,8'h49,4), v(OP_RD,0,8'h42,9),
        v(OP_P,0,0,9),      v(OP_S,0,0,3),      v(OP_B,8'hA0,1,3),  v(OP_B,8'h30,1,3),
        v(OP_S,0,0,3),      v(OP_B,8'hA1,1,3),  v(OP_RD,0,8'h00,3), v(OP_P,0,0,3)
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Called at a falling edge; drives one event for one cycle, returns at the next falling edge
    task automatic step(input int op, input logic [7:0] d);
        start_i      = (op == OP_S);
        stop_i       = (op == OP_P);
        byte_valid_i = (op == OP_B);
        rd_req_i     = (op == OP_RD);
        rx_byte_i    = d;
        @(negedge clk);
        start_i = 1'b0; stop_i = 1'b0; byte_valid_i = 1'b0; rd_req_i = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 ack in reset", {7'd0, ack_o}, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ack after reset", {7'd0, ack_o}, 8'h00);
        check("R1 rd_valid after reset", {7'd0, rd_valid_o}, 8'h00);

        // R1: array reads zero after reset (address 0x7F)
        step(OP_S, 0); step(OP_B, 8'hA0); step(OP_B, 8'h7F);
        step(OP_S, 0); step(OP_B, 8'hA1); step(OP_RD, 0);
        check("R1 rd_valid", {7'd0, rd_valid_o}, 8'h01);
        check("R1 reset array", rd_data_o, 8'h00);
        step(OP_P, 0);

        // Vector table: R2 R3 R4 R5 R7 R8 R9
        for (int i = 0; i < NV; i++) begin
            automatic int         op  = int'(VEC[i][22:20]);
            automatic logic [7:0] d   = VEC[i][19:12];
            automatic logic [7:0] e   = VEC[i][11:4];
            automatic string      req = $sformatf("R%0d vec%0d", VEC[i][3:0], i);
            if (op == OP_I) begin
                repeat (int'(d)) @(negedge clk);
            end else begin
                step(op, d);
                if (op == OP_B) check({req, " ack"}, {7'd0, ack_o}, {7'd0, e[0]});
                if (op == OP_RD) begin
                    check({req, " rd_valid"}, {7'd0, rd_valid_o}, 8'h01);
                    check({req, " data"}, rd_data_o, e);
                end
            end
        end

        // R6 / R7: exact program-cycle window with ACK polling
        step(OP_S, 0); step(OP_B, 8'hA0); step(OP_B, 8'h50); step(OP_B, 8'h99);
        step(OP_P, 0);                    // taken at edge 0 of the cycle
        step(OP_RD, 0);                   // edge 1: read request while busy
        check("R6 no read while busy", {7'd0, rd_valid_o}, 8'h00);
        repeat (PROG_C - 2) @(negedge clk);
        step(OP_S, 0);                    // last busy edge: ignored
        step(OP_B, 8'hA0);
        check("R6 select not acked while busy", {7'd0, ack_o}, 8'h00);
        step(OP_S, 0);
        step(OP_B, 8'hA0);
        check("R7 select acked after cycle", {7'd0, ack_o}, 8'h01);
        step(OP_B, 8'h50);
        step(OP_S, 0); step(OP_B, 8'hA1); step(OP_RD, 0);
        check("R5 committed byte", rd_data_o, 8'h99);
        step(OP_RD, 0);
        check("R5 neighbour untouched", rd_data_o, 8'h00);
        step(OP_P, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule